// File: doc/BRIEF.md
# Bit-Serial Switch Register Master

This block runs a three-wire management link to an Ethernet switch: a chip select, a serial clock and one bidirectional data line. A host hands it one register request at a time over a valid/ready handshake. Each request is either a 16-bit configuration write or a read. The block expands the request into the switch's serial framing and shifts it out most significant bit first. On a read it then lets go of the data line and collects the 32-bit answer. It ends every transaction with two spare clock pulses and releases the link. A one-cycle `done_o` pulse then presents the result.

Bit timing is counted in system clock cycles. `EDGE_CYC` is the minimum interval around each serial clock edge. `SETUP_CYC` is the data setup interval. Each bit slot has three parts:
- a lead part of `EDGE_CYC` cycles, with the clock low and the old data held;
- a setup part of `SETUP_CYC` cycles, with the clock low and the new data driven;
- a high part of `EDGE_CYC` cycles, with the clock high.

Response bits are sampled at the end of the setup part, in the cycle the clock rises. The data-line enable is a separate output, so the pad's tri-state buffer stays outside the block.

The controller is a state machine with seven states:
- ST_IDLE: ready, link released.
- ST_PREP: all pins driven low for `EDGE_CYC`.
- ST_SEL: chip select set to its per-operation level for `EDGE_CYC`.
- ST_CMD: the frame bits.
- ST_RESP: 32 response bits, data line released.
- ST_TAIL: two spare clock pulses, chip select low.
- ST_FIN: clock low for `EDGE_CYC`.

The transitions are:
- ST_IDLE to ST_PREP on accept.
- ST_PREP to ST_SEL, and ST_SEL to ST_CMD, when their timers expire.
- ST_CMD to ST_RESP on a read, or to ST_TAIL on a write, after the last frame bit.
- ST_RESP to ST_TAIL after 32 bits.
- ST_TAIL to ST_FIN after two pulses.
- ST_FIN to ST_IDLE, raising `done_o`.

Top module: `swreg_master`

## Requirements
- R1: A write sends 27 bits, most significant first: 1, 0, 1, then the 8-bit `req_addr`, then the 16-bit `req_wdata`.
- R2: `link_cs` is 1 at every serial clock rise of a write frame and 0 at every rise of a read transaction.
- R3: A read sends 46 bits, most significant first: 32 ones, then 0,1,1,0, then `req_table`, then 0,0, then `req_addr[6:0]`. `req_addr[7]` has no effect on a read.
- R4: Within a frame, `sdo` is constant for at least `SETUP_CYC` cycles before each rise of `link_sclk`, and also during the rise.
- R5: `sdo_oe` is 1 at every frame-bit rise, 0 at every response-bit rise, and 0 while idle.
- R6: After the read frame, 32 bits are taken from `sdi` at the next 32 clock rises, first bit into the most significant position.
- R7: For a read with `req_table`=0, `rdata_o[31:16]` is 0. `rdata_o[15:0]` holds the first 16 received bits if `req_addr[0]`=1, and the last 16 if it is 0.
- R8: For a read with `req_table`=1, `rdata_o` holds all 32 received bits in arrival order.
- R9: Exactly two more clock rises follow the last frame or response bit. After that, `link_oe`, `sdo_oe`, `link_sclk`, `link_cs` and `sdo` are all 0.
- R10: A request is taken only when `req_valid` and `req_ready` are both 1, and `req_ready` is 0 until the transaction ends. `done_o` is a one-cycle pulse exactly 3·EDGE_CYC + N·(2·EDGE_CYC+SETUP_CYC) cycles after the accepting edge. N is 29 for a write and 80 for a read. On a write, `rdata_o` is 0 with `done_o`.
- R11: After reset, `req_ready` is 1, `done_o` is 0, and every link output and enable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_write | input | 1 | 1 = register write, 0 = read |
| req_table | input | 1 | Read table: 0 = 16-bit registers, 1 = 32-bit counters |
| req_addr | input | 8 | Register address (7 bits used on reads) |
| req_wdata | input | 16 | Write data |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| rdata_o | output | 32 | Read result, valid with done_o |
| link_oe | output | 1 | Drive enable for chip select and clock pads |
| link_cs | output | 1 | Chip select |
| link_sclk | output | 1 | Serial clock |
| sdo | output | 1 | Data line output value |
| sdo_oe | output | 1 | Data line drive enable |
| sdi | input | 1 | Data line input value |

## Verification
The one result with a fixed latency is `done_o`. It is due 3·EDGE_CYC + N·(2·EDGE_CYC+SETUP_CYC) cycles after the accepting edge. The bench counts clock edges from acceptance, samples on falling edges, and compares the count to the formula. Every other result ties to serial clock rises rather than to a cycle number, so the bench detects each low-to-high step of `link_sclk` between samples. At each step it takes the data line, the chip select and the enable, and it times how long `sdo` has been unchanged. It feeds each response bit one rise ahead of the point where the design samples it.

// File: rtl/swreg_pkg.sv
package swreg_pkg;

    localparam int WR_BITS   = 27;
    localparam int RD_BITS   = 46;
    localparam int RESP_BITS = 32;
    localparam int TAIL_CLKS = 2;
    localparam int IDX_W     = $clog2(RD_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PREP,
        ST_SEL,
        ST_CMD,
        ST_RESP,
        ST_TAIL,
        ST_FIN
    } link_state_e;

    typedef enum logic [1:0] {
        PH_LEAD,
        PH_SETUP,
        PH_HIGH
    } slot_phase_e;

endpackage

// File: rtl/swreg_timer.sv
module swreg_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/swreg_frame.sv
module swreg_frame
    import swreg_pkg::*;
(
    input  logic               is_write,
    input  logic               tbl,
    input  logic [7:0]         addr,
    input  logic [15:0]        wdata,
    output logic [RD_BITS-1:0] frame,
    output logic [IDX_W-1:0]   last_idx
);
    always_comb begin
        if (is_write) begin
            frame    = {1'b1, 2'b01, addr, wdata, {(RD_BITS-WR_BITS){1'b0}}};
            last_idx = IDX_W'(WR_BITS - 1);
        end else begin
            frame    = {{RESP_BITS{1'b1}}, 2'b01, 2'b10, tbl, 2'b00, addr[6:0]};
            last_idx = IDX_W'(RD_BITS - 1);
        end
    end
endmodule

// File: rtl/swreg_capture.sv
module swreg_capture
    import swreg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clear,
    input  logic                 shift_en,
    input  logic                 sdi,
    input  logic                 tbl,
    input  logic                 odd,
    input  logic                 is_read,
    output logic [RESP_BITS-1:0] rdata
);
    localparam int HALF = RESP_BITS / 2;
    logic [RESP_BITS-1:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        sh <= '0;
        else if (clear)    sh <= '0;
        else if (shift_en) sh <= {sh[RESP_BITS-2:0], sdi};
    end

    always_comb begin
        if (!is_read)  rdata = '0;
        else if (tbl)  rdata = sh;
        else if (odd)  rdata = {{HALF{1'b0}}, sh[RESP_BITS-1:HALF]};
        else           rdata = {{HALF{1'b0}}, sh[HALF-1:0]};
    end
endmodule

// File: rtl/swreg_master.sv
module swreg_master
    import swreg_pkg::*;
#(
    parameter int EDGE_CYC  = 150,
    parameter int SETUP_CYC = 50
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic        req_write,
    input  logic        req_table,
    input  logic [7:0]  req_addr,
    input  logic [15:0] req_wdata,
    output logic        done_o,
    output logic [31:0] rdata_o,
    output logic        link_oe,
    output logic        link_cs,
    output logic        link_sclk,
    output logic        sdo,
    output logic        sdo_oe,
    input  logic        sdi
);
    localparam int MAXPH = (EDGE_CYC > SETUP_CYC) ? EDGE_CYC : SETUP_CYC;
    localparam int TW    = $clog2(MAXPH + 1);
    localparam logic [TW-1:0] EDGE_L  = TW'(EDGE_CYC - 1);
    localparam logic [TW-1:0] SETUP_L = TW'(SETUP_CYC - 1);

    link_state_e          state, state_n;
    slot_phase_e          ph, ph_n;
    logic [IDX_W-1:0]     bits, bits_n, last_q, last_idx;
    logic [RD_BITS-1:0]   shreg, frame;
    logic                 sdo_q, wr_q, tbl_q, odd_q;
    logic                 tmr_ld, tmr_exp, accept, shift_out, cap_en, fin;
    logic [TW-1:0]        tmr_val;

    swreg_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .expired(tmr_exp)
    );

    swreg_frame u_frame (
        .is_write(req_write), .tbl(req_table), .addr(req_addr), .wdata(req_wdata),
        .frame(frame), .last_idx(last_idx)
    );

    swreg_capture u_cap (
        .clk(clk), .rst_n(rst_n), .clear(accept), .shift_en(cap_en), .sdi(sdi),
        .tbl(tbl_q), .odd(odd_q), .is_read(!wr_q), .rdata(rdata_o)
    );

    // next-state and control strobes
    always_comb begin
        state_n   = state;
        ph_n      = ph;
        bits_n    = bits;
        tmr_ld    = 1'b0;
        tmr_val   = EDGE_L;
        accept    = 1'b0;
        shift_out = 1'b0;
        cap_en    = 1'b0;
        fin       = 1'b0;
        unique case (state)
            ST_IDLE: if (req_valid) begin
                accept  = 1'b1;
                state_n = ST_PREP;
                tmr_ld  = 1'b1;
            end
            ST_PREP: if (tmr_exp) begin
                state_n = ST_SEL;
                tmr_ld  = 1'b1;
            end
            ST_SEL: if (tmr_exp) begin
                state_n = ST_CMD;
                ph_n    = PH_LEAD;
                bits_n  = last_q;
                tmr_ld  = 1'b1;
            end
            ST_CMD, ST_RESP, ST_TAIL: if (tmr_exp) begin
                tmr_ld = 1'b1;
                unique case (ph)
                    PH_LEAD: begin
                        ph_n      = PH_SETUP;
                        tmr_val   = SETUP_L;
                        shift_out = (state == ST_CMD);
                    end
                    PH_SETUP: begin
                        ph_n   = PH_HIGH;
                        cap_en = (state == ST_RESP);
                    end
                    PH_HIGH: begin
                        ph_n = PH_LEAD;
                        if (bits != '0) begin
                            bits_n = bits - 1'b1;
                        end else if (state == ST_CMD && !wr_q) begin
                            state_n = ST_RESP;
                            bits_n  = IDX_W'(RESP_BITS - 1);
                        end else if (state == ST_TAIL) begin
                            state_n = ST_FIN;
                        end else begin
                            state_n = ST_TAIL;
                            bits_n  = IDX_W'(TAIL_CLKS - 1);
                        end
                    end
                    default: ph_n = PH_LEAD;
                endcase
            end
            ST_FIN: if (tmr_exp) begin
                state_n = ST_IDLE;
                fin     = 1'b1;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            ph     <= PH_LEAD;
            bits   <= '0;
            last_q <= '0;
            shreg  <= '0;
            sdo_q  <= 1'b0;
            wr_q   <= 1'b0;
            tbl_q  <= 1'b0;
            odd_q  <= 1'b0;
            done_o <= 1'b0;
        end else begin
            state  <= state_n;
            ph     <= ph_n;
            bits   <= bits_n;
            done_o <= fin;
            if (accept) begin
                shreg  <= frame;
                last_q <= last_idx;
                wr_q   <= req_write;
                tbl_q  <= req_table;
                odd_q  <= req_addr[0];
                sdo_q  <= 1'b0;
            end else if (shift_out) begin
                sdo_q <= shreg[RD_BITS-1];
                shreg <= {shreg[RD_BITS-2:0], 1'b0};
            end
        end
    end

    // pin outputs
    always_comb begin
        req_ready = (state == ST_IDLE);
        link_oe   = (state != ST_IDLE);
        link_cs   = wr_q && (state == ST_SEL || state == ST_CMD);
        link_sclk = (state == ST_CMD || state == ST_RESP || state == ST_TAIL) && (ph == PH_HIGH);
        sdo       = (state == ST_CMD) ? sdo_q : 1'b0;
        sdo_oe    = (state == ST_PREP || state == ST_SEL || state == ST_CMD)
                 || (state == ST_TAIL && wr_q);
    end

    p_setup_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(link_sclk) && sdo_oe) |-> $stable(sdo));

    p_cs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        link_sclk |-> $stable(link_cs));

    p_sample_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |-> !sdo_oe);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (req_ready && !link_oe && !sdo_oe && !link_sclk));

    p_busy_after_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    initial begin
        assert (EDGE_CYC >= 1 && SETUP_CYC >= 1);
    end
endmodule

// File: tb/tb_swreg_master.sv
module tb_swreg_master;
    localparam int E = 3;
    localparam int S = 2;

    logic        clk = 1'b0;
    logic        rst_n, req_valid, req_ready, req_write, req_table;
    logic [7:0]  req_addr;
    logic [15:0] req_wdata;
    logic        done_o, link_oe, link_cs, link_sclk, sdo, sdo_oe, sdi;
    logic [31:0] rdata_o;
    int          vecs = 0;
    int          errs = 0;

    always #10 clk = ~clk;

    swreg_master #(.EDGE_CYC(E), .SETUP_CYC(S)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_table(req_table), .req_addr(req_addr),
        .req_wdata(req_wdata), .done_o(done_o), .rdata_o(rdata_o), .link_oe(link_oe),
        .link_cs(link_cs), .link_sclk(link_sclk), .sdo(sdo), .sdo_oe(sdo_oe), .sdi(sdi)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        vecs++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run(input bit wr, input bit tbl, input logic [7:0] a,
                       input logic [15:0] wd, input logic [31:0] resp);
        int nb, respn, tcyc, n, rc, stab;
        logic [45:0] expf, got;
        logic [31:0] exp_rd;
        bit pc, ps, seen, e_cs, e_oe, e_st, e_rd, busy_bad;
        nb    = wr ? 27 : 46;
        respn = wr ? 0 : 32;
        tcyc  = 3*E + (nb + respn + 2) * (2*E + S);
        expf  = wr ? {19'b0, 1'b1, 2'b01, a, wd}
                   : {32'hFFFF_FFFF, 4'b0110, tbl, 2'b00, a[6:0]};
        exp_rd = wr ? 32'h0 : (tbl ? resp : (a[0] ? {16'h0, resp[31:16]} : {16'h0, resp[15:0]}));
        got = '0; rc = 0; stab = 0; seen = 0;
        e_cs = 0; e_oe = 0; e_st = 0; e_rd = 0; busy_bad = 0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_table = tbl; req_addr = a; req_wdata = wd; sdi = 1'b0;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 0; pc = link_sclk; ps = sdo;
        while (!seen && n < 5000) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (done_o) seen = 1;
            else if (req_ready) busy_bad = 1;
            if (sdo !== ps) stab = 0; else stab++;
            ps = sdo;
            if (link_sclk && !pc) begin
                rc++;
                if (rc <= nb) begin
                    got = {got[44:0], sdo};
                    if (link_cs !== wr) e_cs = 1;
                    if (sdo_oe !== 1'b1) e_oe = 1;
                    if (stab < S) e_st = 1;
                end else if (rc <= nb + respn) begin
                    if (sdo_oe !== 1'b0 || link_cs !== 1'b0) e_rd = 1;
                end
                if (!wr && rc >= nb && rc < nb + 32) sdi = resp[31 - (rc - nb)];
            end
            pc = link_sclk;
        end
        check(seen && n == tcyc, "R10 done latency", 64'(n), 64'(tcyc));
        check(rc == nb + respn + 2, "R9 clock rise count", 64'(rc), 64'(nb + respn + 2));
        if (wr) check(got[26:0] == expf[26:0], "R1 write frame", 64'(got[26:0]), 64'(expf[26:0]));
        else    check(got == expf, "R3 read frame", 64'(got), 64'(expf));
        check(!e_cs, "R2 chip select level", 64'(e_cs), 64'(0));
        check(!e_st, "R4 data setup", 64'(e_st), 64'(0));
        check(!e_oe && !e_rd, "R5 data enable", 64'({e_oe, e_rd}), 64'(0));
        check(rdata_o == exp_rd, wr ? "R10 write rdata" : (tbl ? "R8 counter read (R6)" : "R7 half select (R6)"),
              64'(rdata_o), 64'(exp_rd));
        check(!busy_bad, "R10 ready while busy", 64'(busy_bad), 64'(0));
        check({link_oe, sdo_oe, link_sclk, link_cs, sdo, req_ready} == 6'b000001,
              "R9 released at done", 64'({link_oe, sdo_oe, link_sclk, link_cs, sdo, req_ready}), 64'(1));
        @(posedge clk);
        @(negedge clk);
        check(done_o == 1'b0, "R10 done single cycle", 64'(done_o), 64'(0));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end

    initial begin
        logic [7:0] addrs [6];
        addrs = '{8'h00, 8'h01, 8'h02, 8'h07, 8'h42, 8'hFF};
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_table = 1'b0;
        req_addr = '0; req_wdata = '0; sdi = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check({req_ready, done_o, link_oe, sdo_oe, link_sclk, link_cs, sdo} == 7'b1000000,
              "R11 reset state", 64'({req_ready, done_o, link_oe, sdo_oe, link_sclk, link_cs, sdo}), 64'h40);
        for (int t = 0; t < 2; t++) begin
            for (int k = 0; k < 6; k++) begin
                logic [7:0] a;
                a = addrs[k];
                run(1'b0, t[0], a, 16'h0, {a, ~a, a ^ 8'h3C, 8'h96} ^ (t[0] ? 32'hF0F0_0F0F : 32'h0));
            end
        end
        for (int k = 0; k < 16; k++) begin
            run(1'b1, k[0], 8'(k * 17), 16'hA5C3 ^ 16'(k * 16'h1111), 32'h0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
        $finish;
    end
endmodule